// File: doc/BRIEF.md
# SDA Stuck-Low Recovery Sequencer

This block opens every bus access of an I2C master. When the master asks for a START condition (a first START, a forced access after a bus time-out, or a repeated START), the sequencer first releases both lines for a set-up phase. It then samples SDA. If SDA is HIGH, it drives the START and hands the bus on with SCL held LOW. If a slave that has lost bit synchronisation holds SDA LOW, the sequencer clocks the slave out with exactly nine SCL pulses while it leaves SDA free. It then builds a STOP condition and samples SDA again. A released line leads to a normal START. A line that is still held leads to a terminal bus-error state. The bus error is reported through a status code and an interrupt. Only a reset clears it. No host action is needed at any point of the sequence.

The `scl_in` and `sda_in` inputs are the already-synchronised bus levels. The two `*_drive_low` outputs control the open-drain pull-downs. The set-up and high phases count only the cycles in which SCL actually reads HIGH. A slave that stretches the clock therefore lengthens the sequence instead of shortening a phase.

States and transitions:
- IDLE goes to SETUP on a request.
- OWNED goes to SETUP on a request (repeated START).
- SETUP goes to START_HOLD if SDA is HIGH, and to PULSE_LO if SDA is LOW.
- PULSE_LO goes to PULSE_HI.
- PULSE_HI goes back to PULSE_LO, or to STOP_LO after the last pulse.
- STOP_LO goes to STOP_SCL, and STOP_SCL goes to STOP_SDA.
- STOP_SDA goes to START_HOLD if SDA is HIGH, and to BUS_ERR if SDA is LOW.
- START_HOLD goes to OWNED.
- BUS_ERR is left only through reset.

Top module: `sda_unstick`

## Requirements
- R1: After reset, both drive outputs are 0, `status` is F8h and `irq` is 0.
- R2: On a request with SDA HIGH, both lines stay released for HIGH_CYCLES counted cycles. SDA is then driven LOW with SCL released for HIGH_CYCLES counted cycles. After that, `status` becomes 08h with SCL driven LOW and SDA released, 2*HIGH_CYCLES cycles after the request edge.
- R3: If SDA reads LOW at the end of the set-up phase, exactly NUM_PULSES (default 9) SCL low pulses are driven, and SDA is released during all of them.
- R4: Each pulse drives SCL LOW for LOW_CYCLES cycles and then releases it for HIGH_CYCLES cycles. The set-up and high phases advance only on cycles where `scl_in` is 1, so clock stretching adds to the total time.
- R5: After the pulses, a STOP is formed in three steps: SDA is driven LOW while SCL is LOW for LOW_CYCLES, then SCL is released, then SDA is released HIGH_CYCLES cycles later. A further HIGH_CYCLES bus-free phase follows.
- R6: If SDA reads HIGH at the end of the bus-free phase, a START as in R2 follows and `status` becomes 08h.
- R7: If SDA still reads LOW at that point, `status` becomes 70h, `irq` becomes 1 and both lines are released.
- R8: Once in status 70h, requests are ignored and the lines stay released until reset.
- R9: A request made in status 08h (repeated START) runs the same set-up, check and recovery procedure.
- R10: `irq` is 1 only in status 70h. The status stays F8h while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (hardware or software) |
| start_req | input | 1 | One-cycle request for a START condition |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| scl_drive_low | output | 1 | 1 pulls SCL LOW |
| sda_drive_low | output | 1 | 1 pulls SDA LOW |
| status | output | 8 | F8h busy/idle, 08h START done, 70h bus error |
| irq | output | 1 | Bus-error interrupt |

## Verification
The bench builds the block with LOW_CYCLES=4, HIGH_CYCLES=3 and the default nine pulses. With these values a whole recovery takes 79 cycles. This lets the bench check exact end-to-end latencies, which pins down every phase length, the pulse count, the STOP timing and the effect of clock stretching on the counted phases. A bus model with a slave that releases SDA after a chosen number of SCL rising edges covers these cases: release at the first edge, release at the last pulse, release during the STOP, and no release at all.

// File: rtl/sdarec_pkg.sv
package sdarec_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_PULSE_LO,
        S_PULSE_HI,
        S_STOP_LO,
        S_STOP_SCL,
        S_STOP_SDA,
        S_START_HOLD,
        S_OWNED,
        S_BUS_ERR
    } rec_state_e;

    localparam logic [7:0] CODE_QUIET   = 8'hF8;
    localparam logic [7:0] CODE_STARTED = 8'h08;
    localparam logic [7:0] CODE_BUSERR  = 8'h70;

endpackage

// File: rtl/sdarec_timer.sv
module sdarec_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (enable) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = enable && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/sdarec_pulse_cnt.sv
module sdarec_pulse_cnt #(
    parameter int unsigned NUM_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int unsigned PCNT_W = $clog2(NUM_PULSES + 1);

    logic [PCNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == PCNT_W'(NUM_PULSES - 1));
endmodule

// File: rtl/sda_unstick.sv
module sda_unstick
    import sdarec_pkg::*;
#(
    parameter int unsigned LOW_CYCLES  = 250,
    parameter int unsigned HIGH_CYCLES = 250,
    parameter int unsigned NUM_PULSES  = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic [7:0] status,
    output logic       irq
);
    localparam int unsigned MAX_PHASE = (LOW_CYCLES > HIGH_CYCLES) ? LOW_CYCLES : HIGH_CYCLES;
    localparam int unsigned CNT_W     = $clog2(MAX_PHASE + 1);

    rec_state_e       state_q, state_d;
    logic             phase_done;
    logic             timer_en;
    logic             restart;
    logic             last_pulse;
    logic             pulse_step;
    logic             pulse_clr;
    logic [CNT_W-1:0] phase_limit;

    // Phase length and counting condition per state
    always_comb begin
        phase_limit = CNT_W'(HIGH_CYCLES);
        if (state_q == S_PULSE_LO || state_q == S_STOP_LO) begin
            phase_limit = CNT_W'(LOW_CYCLES);
        end
    end

    always_comb begin
        unique case (state_q)
            S_PULSE_LO, S_STOP_LO:                                    timer_en = 1'b1;
            S_SETUP, S_PULSE_HI, S_STOP_SCL, S_STOP_SDA, S_START_HOLD: timer_en = scl_in;
            default:                                                  timer_en = 1'b0;
        endcase
    end

    sdarec_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .enable  (timer_en),
        .limit   (phase_limit),
        .done    (phase_done)
    );

    assign pulse_step = (state_q == S_PULSE_HI) && phase_done;
    assign pulse_clr  = (state_q == S_SETUP);

    sdarec_pulse_cnt #(
        .NUM_PULSES (NUM_PULSES)
    ) i_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pulse_clr),
        .step  (pulse_step),
        .last  (last_pulse)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_OWNED: if (start_req) state_d = S_SETUP;
            S_SETUP:         if (phase_done) state_d = sda_in ? S_START_HOLD : S_PULSE_LO;
            S_PULSE_LO:      if (phase_done) state_d = S_PULSE_HI;
            S_PULSE_HI:      if (phase_done) state_d = last_pulse ? S_STOP_LO : S_PULSE_LO;
            S_STOP_LO:       if (phase_done) state_d = S_STOP_SCL;
            S_STOP_SCL:      if (phase_done) state_d = S_STOP_SDA;
            S_STOP_SDA:      if (phase_done) state_d = sda_in ? S_START_HOLD : S_BUS_ERR;
            S_START_HOLD:    if (phase_done) state_d = S_OWNED;
            S_BUS_ERR:       state_d = S_BUS_ERR;
            default:         state_d = S_IDLE;
        endcase
    end

    assign restart = (state_d != state_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        status        = CODE_QUIET;
        irq           = 1'b0;
        unique case (state_q)
            S_PULSE_LO:   scl_drive_low = 1'b1;
            S_STOP_LO: begin
                scl_drive_low = 1'b1;
                sda_drive_low = 1'b1;
            end
            S_STOP_SCL:   sda_drive_low = 1'b1;
            S_START_HOLD: sda_drive_low = 1'b1;
            S_OWNED: begin
                scl_drive_low = 1'b1;
                status        = CODE_STARTED;
            end
            S_BUS_ERR: begin
                status = CODE_BUSERR;
                irq    = 1'b1;
            end
            default: begin
                scl_drive_low = 1'b0;
                sda_drive_low = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sda_unstick_chk.sv
module sda_unstick_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       scl_in,
    input logic       sda_in,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic [7:0] status,
    input logic       irq
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == 8'hF8 && !irq && !scl_drive_low && !sda_drive_low));

    p_owned_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h08) |-> (scl_drive_low && !sda_drive_low));

    p_start_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status) && status == 8'h08) |-> ($past(sda_drive_low) && !$past(scl_drive_low)));

    p_stop_sda_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low && scl_drive_low) |=> sda_drive_low);

    p_error_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h70) |-> (irq && !scl_drive_low && !sda_drive_low));

    p_error_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h70) |=> (status == 8'h70));

    p_irq_only_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status == 8'h70));
endmodule

bind sda_unstick sda_unstick_chk i_sda_unstick_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_req     (start_req),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .status        (status),
    .irq           (irq)
);

// File: tb/test_sda_unstick.sv
`timescale 1ns/1ps
module test_sda_unstick;
    localparam int TL = 4;
    localparam int TH = 3;
    localparam int NP = 9;
    localparam int LAT_OK  = 2 * TH;
    localparam int LAT_REC = TH + NP * (TL + TH) + TL + 3 * TH;
    localparam int LAT_ERR = LAT_REC - TH;
    localparam int NV = 7;
    // columns: slave hold edges (0 none, 15 never), stretch, status, pulses, stops, latency
    localparam int VEC [NV][6] = '{
        '{0,  0, 8,   0,  0, LAT_OK},
        '{1,  0, 8,   NP, 1, LAT_REC},
        '{9,  0, 8,   NP, 1, LAT_REC},
        '{10, 0, 8,   NP, 1, LAT_REC},
        '{0,  6, 8,   0,  0, LAT_OK + 5},
        '{4,  6, 8,   NP, 1, LAT_REC + 5},
        '{15, 0, 112, NP, 1, LAT_ERR}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       scl_in, sda_in;
    logic       scl_drive_low, sda_drive_low, irq;
    logic [7:0] status;
    logic       slave_hold, ext_scl_low;

    int hold_k = 0, stretch_left = 0, rises = 0;
    int pulses = 0, bad_low = 0, lowrun = 0, stop_ph = 0, gap = 0, stops_ok = 0, irq_bad = 0;
    int tests = 0, fails = 0;
    logic prev_scl_drv = 1'b0, prev_sda_drv = 1'b0, prev_scl_in = 1'b1;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    assign ext_scl_low = (stretch_left > 0);
    assign slave_hold  = (hold_k != 0) && (hold_k == 15 || rises < hold_k);
    assign scl_in      = !(scl_drive_low || ext_scl_low);
    assign sda_in      = !(sda_drive_low || slave_hold);

    sda_unstick #(
        .LOW_CYCLES  (TL),
        .HIGH_CYCLES (TH),
        .NUM_PULSES  (NP)
    ) i_sda_unstick (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_req     (start_req),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .status        (status),
        .irq           (irq)
    );

    // Bus monitor, sampled 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (stretch_left > 0) stretch_left--;
        if ((status == 8'h70) != irq) irq_bad++;
        if (start_req) begin
            pulses = 0; bad_low = 0; lowrun = 0; stop_ph = 0; gap = 0; stops_ok = 0; rises = 0;
        end else begin
            if (scl_in && !prev_scl_in) rises++;
            if (scl_drive_low && !prev_scl_drv && !sda_drive_low && status == 8'hF8) begin
                pulses++;
                lowrun = 1;
            end else if (scl_drive_low && !sda_drive_low && lowrun != 0) begin
                lowrun++;
            end
            if (!scl_drive_low && prev_scl_drv && !prev_sda_drv && lowrun != 0) begin
                if (lowrun != TL) bad_low++;
                lowrun = 0;
            end
            if (sda_drive_low && !prev_sda_drv && scl_drive_low) stop_ph = 1;
            if (stop_ph == 1 && !scl_drive_low && prev_scl_drv && sda_drive_low) begin
                stop_ph = 2;
                gap = 1;
            end else if (stop_ph == 2 && sda_drive_low) begin
                gap++;
            end
            if (stop_ph == 2 && !sda_drive_low) begin
                if (gap == TH) stops_ok++;
                stop_ph = 0;
            end
        end
        prev_scl_drv = scl_drive_low;
        prev_sda_drv = sda_drive_low;
        prev_scl_in  = scl_in;
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hold_k = 0;
        stretch_left = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic request(input int hk, input int st, output int lat);
        hold_k = hk;
        stretch_left = st;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        lat = 0;
        while (status == 8'hF8 && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int lat;
        do_reset();
        // R1: reset state
        check("R1 status after reset", status, 8'hF8);
        check("R1 irq after reset", irq, 0);
        check("R1 scl drive after reset", scl_drive_low, 0);
        check("R1 sda drive after reset", sda_drive_low, 0);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            do_reset();
            request(VEC[i][0], VEC[i][1], lat);
            check($sformatf("R6/R7 vec%0d status", i), status, VEC[i][2]);
            check($sformatf("R3 vec%0d pulse count", i), pulses, VEC[i][3]);
            check($sformatf("R4 vec%0d low phase length errors", i), bad_low, 0);
            check($sformatf("R5 vec%0d STOP sequences", i), stops_ok, VEC[i][4]);
            check($sformatf("R2/R4 vec%0d latency", i), lat, VEC[i][5]);
            if (VEC[i][2] == 8) begin
                check($sformatf("R2 vec%0d scl held", i), scl_drive_low, 1);
                check($sformatf("R2 vec%0d sda free", i), sda_drive_low, 0);
            end else begin
                check("R7 irq raised", irq, 1);
                check("R7 scl released", scl_drive_low, 0);
                check("R7 sda released", sda_drive_low, 0);
            end
        end

        // R8: requests ignored in bus error
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (100) @(negedge clk);
        check("R8 status stays 70h", status, 8'h70);
        check("R8 no pulses after request", pulses, 0);
        check("R8 scl released", scl_drive_low, 0);
        check("R8 sda released", sda_drive_low, 0);
        do_reset();
        check("R8 reset leaves error", status, 8'hF8);
        check("R8 irq cleared by reset", irq, 0);

        // R9: repeated START from status 08h with SDA stuck
        do_reset();
        request(0, 0, lat);
        check("R9 first start status", status, 8'h08);
        @(negedge clk);
        request(5, 0, lat);
        check("R9 repeated start status", status, 8'h08);
        check("R9 repeated start pulses", pulses, NP);
        check("R9 repeated start STOP", stops_ok, 1);
        check("R9 repeated start latency", lat, LAT_REC);

        // R10: irq only in error, over the whole run
        check("R10 irq consistency", irq_bad, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule